// File: doc/BRIEF.md
# Dual-Channel Burst Pulse Generator

This block drives two output pins, each with a train of pulses. Every channel holds its own high duration, its own low duration and a pulse count. All three are measured in ticks of an external strobe that arrives once every 100 µs. A single enable mask starts and stops the channels. An enabled channel begins in its high phase. It then alternates between high and low, and stops low once it has emitted the programmed number of pulses. A pulse count of zero makes the channel run until it is disabled.

Configuration arrives through a write port that carries an 8-bit command code and a 16-bit value. The same codes, presented on a read port, return the stored value one clock later. Durations and counts are frozen while their channel runs. To re-arm a burst, the host disables the channel, loads new settings and enables it again.

Top module: `dual_burst_pulser`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `pwm_out` is 0, every stored duration, count and mask bit is 0, and `rd_data` is 0.
- R2: A write with `wr_en` high stores `wr_data` according to its code. Code 0x10+2x sets channel x's high duration and 0x11+2x sets its low duration. Code 0x14+x sets channel x's pulse count. Code 0x1F loads the enable mask from `wr_data` bit x for channel x. A code placed on `rd_code` returns the stored value on `rd_data` in the next cycle, with the mask zero-extended. Any other code reads back as 0.
- R3: A duration or count write to a channel whose mask bit is set is ignored, and the stored value reads back unchanged.
- R4: A channel's output goes high at the clock edge that stores its mask bit as 1. It then stays high for the high duration, counted in sampled `tick` strobes, and low for the low duration, and this repeats.
- R5: A channel's output goes low at the clock edge that stores its mask bit as 0. A later enable restarts the channel from the high phase with a full pulse count.
- R6: With a pulse count N greater than 0, exactly N pulses are produced, and the output then stays low while the channel remains enabled.
- R7: With a pulse count of 0, the channel keeps pulsing for as long as it is enabled.
- R8: A duration of 0 behaves as a duration of 1 tick.
- R9: While its mask bit stays set, an output changes only at an edge where `tick` is sampled high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle strobe, once per 100 µs time unit |
| wr_en | input | 1 | Write strobe for configuration |
| wr_code | input | 8 | Command code that selects the target of a write |
| wr_data | input | 16 | Value to store |
| rd_code | input | 8 | Command code to read back |
| rd_data | output | 16 | Stored value for `rd_code`, registered |
| pwm_out | output | 2 | Pulse outputs, bit x for channel x |

## Verification
Channel 0 runs a finite burst with unequal high and low durations, while channel 1 runs continuously with both durations set to zero. This separates burst termination from free running, and shows that the zero-duration substitution is correct. Ticks arrive every five cycles, so a design that counts clocks instead of strobes breaks the per-cycle comparison with the reference model. A duration write issued while the channel is enabled, an immediate disable, and a re-arm with a single-pulse burst cover the freeze, forced-low and restart behaviours.

// File: rtl/pulser_pkg.sv
package pulser_pkg;
  typedef enum logic [1:0] {
    PH_HIGH = 2'd0,
    PH_LOW  = 2'd1,
    PH_DONE = 2'd2
  } phase_e;

  // command code bases decoded by the host-side mailbox logic
  localparam int HI_CODE_BASE  = 'h10;  // high duration of ch x at base + 2x
  localparam int LO_CODE_BASE  = 'h11;  // low duration of ch x at base + 2x
  localparam int CNT_CODE_BASE = 'h14;  // pulse count of ch x at base + x
  localparam int MASK_CODE     = 'h1F;  // enable mask, bit x for ch x
endpackage

// File: rtl/pulser_regs.sv
module pulser_regs
  import pulser_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int PER_W  = 16,
  parameter int CODE_W = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr_en,
  input  logic [CODE_W-1:0]            wr_code,
  input  logic [PER_W-1:0]             wr_data,
  input  logic [CODE_W-1:0]            rd_code,
  output logic [PER_W-1:0]             rd_data,
  output logic [NUM_CH-1:0]            mask_q,
  output logic [NUM_CH-1:0]            mask_d,
  output logic [NUM_CH-1:0][PER_W-1:0] hi_per,
  output logic [NUM_CH-1:0][PER_W-1:0] lo_per,
  output logic [NUM_CH-1:0][PER_W-1:0] burst
);
  logic [PER_W-1:0] rd_next;

  always_comb begin
    mask_d = mask_q;
    if (wr_en && wr_code == CODE_W'(MASK_CODE))
      mask_d = wr_data[NUM_CH-1:0];
  end

  // duration and count writes are blocked while the channel is running
  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      hi_per <= '0;
      lo_per <= '0;
      burst  <= '0;
    end else begin
      mask_q <= mask_d;
      for (int i = 0; i < NUM_CH; i++) begin
        if (wr_en && !mask_q[i]) begin
          if (wr_code == CODE_W'(HI_CODE_BASE + 2*i)) hi_per[i] <= wr_data;
          if (wr_code == CODE_W'(LO_CODE_BASE + 2*i)) lo_per[i] <= wr_data;
          if (wr_code == CODE_W'(CNT_CODE_BASE + i))  burst[i]  <= wr_data;
        end
      end
    end
  end

  always_comb begin
    rd_next = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (rd_code == CODE_W'(HI_CODE_BASE + 2*i)) rd_next = hi_per[i];
      if (rd_code == CODE_W'(LO_CODE_BASE + 2*i)) rd_next = lo_per[i];
      if (rd_code == CODE_W'(CNT_CODE_BASE + i))  rd_next = burst[i];
    end
    if (rd_code == CODE_W'(MASK_CODE)) rd_next = PER_W'(mask_q);
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_next;
  end
endmodule

// File: rtl/pulser_chan.sv
module pulser_chan
  import pulser_pkg::*;
#(
  parameter int PER_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             en_q,
  input  logic             en_d,
  input  logic [PER_W-1:0] hi_per,
  input  logic [PER_W-1:0] lo_per,
  input  logic [PER_W-1:0] burst,
  output logic             out
);
  localparam int CW = PER_W + 1;

  phase_e           ph, ph_n;
  logic [PER_W-1:0] cnt, cnt_n;
  logic [PER_W-1:0] rem, rem_n;
  logic [CW-1:0]    cnt_inc, eff_hi, eff_lo;

  assign cnt_inc = {1'b0, cnt} + CW'(1);
  assign eff_hi  = (hi_per == '0) ? CW'(1) : {1'b0, hi_per};
  assign eff_lo  = (lo_per == '0) ? CW'(1) : {1'b0, lo_per};

  always_comb begin
    ph_n  = ph;
    cnt_n = cnt;
    rem_n = rem;
    if (!en_q) begin
      ph_n  = PH_HIGH;
      cnt_n = '0;
      rem_n = burst;
    end else if (tick) begin
      case (ph)
        PH_HIGH: begin
          if (cnt_inc >= eff_hi) begin
            ph_n  = PH_LOW;
            cnt_n = '0;
          end else begin
            cnt_n = cnt_inc[PER_W-1:0];
          end
        end
        PH_LOW: begin
          if (cnt_inc >= eff_lo) begin
            cnt_n = '0;
            if (burst == '0) begin
              ph_n = PH_HIGH;
            end else if (rem > PER_W'(1)) begin
              rem_n = rem - PER_W'(1);
              ph_n  = PH_HIGH;
            end else begin
              rem_n = '0;
              ph_n  = PH_DONE;
            end
          end else begin
            cnt_n = cnt_inc[PER_W-1:0];
          end
        end
        default: ph_n = PH_DONE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph  <= PH_HIGH;
      cnt <= '0;
      rem <= '0;
      out <= 1'b0;
    end else begin
      ph  <= ph_n;
      cnt <= cnt_n;
      rem <= rem_n;
      out <= en_d && (ph_n == PH_HIGH);
    end
  end
endmodule

// File: rtl/dual_burst_pulser.sv
module dual_burst_pulser
  import pulser_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int PER_W  = 16,
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [CODE_W-1:0] wr_code,
  input  logic [PER_W-1:0]  wr_data,
  input  logic [CODE_W-1:0] rd_code,
  output logic [PER_W-1:0]  rd_data,
  output logic [NUM_CH-1:0] pwm_out
);
  logic [NUM_CH-1:0]            mask_q, mask_d;
  logic [NUM_CH-1:0][PER_W-1:0] hi_per, lo_per, burst;

  pulser_regs #(.NUM_CH(NUM_CH), .PER_W(PER_W), .CODE_W(CODE_W)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_code (wr_code),
    .wr_data (wr_data),
    .rd_code (rd_code),
    .rd_data (rd_data),
    .mask_q  (mask_q),
    .mask_d  (mask_d),
    .hi_per  (hi_per),
    .lo_per  (lo_per),
    .burst   (burst)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    pulser_chan #(.PER_W(PER_W)) u_chan (
      .clk    (clk),
      .rst    (rst),
      .tick   (tick),
      .en_q   (mask_q[g]),
      .en_d   (mask_d[g]),
      .hi_per (hi_per[g]),
      .lo_per (lo_per[g]),
      .burst  (burst[g]),
      .out    (pwm_out[g])
    );
  end
endmodule

// File: rtl/pulser_chk.sv
module pulser_chk #(
  parameter int NUM_CH = 2,
  parameter int PER_W  = 16
) (
  input logic                         clk,
  input logic                         rst,
  input logic                         tick,
  input logic [NUM_CH-1:0]            mask,
  input logic [NUM_CH-1:0]            pwm,
  input logic [NUM_CH-1:0][PER_W-1:0] hi,
  input logic [NUM_CH-1:0][PER_W-1:0] lo
);
  for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
    a_r5_off_low: assert property (@(posedge clk) disable iff (rst)
      !mask[g] |-> !pwm[g]);
    a_r4_enable_high: assert property (@(posedge clk) disable iff (rst)
      $rose(mask[g]) |-> pwm[g]);
    a_r9_tick_paced: assert property (@(posedge clk) disable iff (rst)
      (mask[g] && $past(mask[g]) && !$past(tick)) |-> $stable(pwm[g]));
    a_r3_frozen_periods: assert property (@(posedge clk) disable iff (rst)
      $past(mask[g]) |-> ($stable(hi[g]) && $stable(lo[g])));
  end
endmodule

bind dual_burst_pulser pulser_chk #(.NUM_CH(NUM_CH), .PER_W(PER_W)) u_chk (
  .clk  (clk),
  .rst  (rst),
  .tick (tick),
  .mask (mask_q),
  .pwm  (pwm_out),
  .hi   (hi_per),
  .lo   (lo_per)
);

// File: tb/dual_burst_pulser_tb.sv
module dual_burst_pulser_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_code = '0;
  logic [15:0] wr_data = '0;
  logic [7:0]  rd_code = '0;
  logic [15:0] rd_data;
  logic [1:0]  pwm_out;

  int checks = 0;
  int errors = 0;
  bit tick_run = 1'b0;
  bit started = 1'b0;
  bit done = 1'b0;
  int cycles = 0;

  // reference model state: phase 0 high, 1 low, 2 finished
  int m_ph[2], m_cnt[2], m_rem[2], m_hi[2], m_lo[2], m_bc[2];
  bit [1:0] m_mask, m_nmask;
  bit [1:0] m_out;
  int eh, el;
  int rise[2];
  bit [1:0] prev_out;

  always #2 clk = ~clk;

  dual_burst_pulser u_dut (
    .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .wr_code(wr_code),
    .wr_data(wr_data), .rd_code(rd_code), .rd_data(rd_data), .pwm_out(pwm_out)
  );

  always @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < 2; c++) begin
        m_ph[c] = 0; m_cnt[c] = 0; m_rem[c] = 0;
        m_hi[c] = 0; m_lo[c] = 0; m_bc[c] = 0;
      end
      m_mask = '0;
      m_out = '0;
    end else begin
      m_nmask = m_mask;
      if (wr_en && wr_code == 8'h1F) m_nmask = wr_data[1:0];
      for (int c = 0; c < 2; c++) begin
        eh = (m_hi[c] == 0) ? 1 : m_hi[c];
        el = (m_lo[c] == 0) ? 1 : m_lo[c];
        if (!m_mask[c]) begin
          m_ph[c] = 0; m_cnt[c] = 0; m_rem[c] = m_bc[c];
        end else if (tick) begin
          if (m_ph[c] == 0) begin
            if (m_cnt[c] + 1 >= eh) begin m_ph[c] = 1; m_cnt[c] = 0; end
            else m_cnt[c] = m_cnt[c] + 1;
          end else if (m_ph[c] == 1) begin
            if (m_cnt[c] + 1 >= el) begin
              m_cnt[c] = 0;
              if (m_bc[c] == 0) m_ph[c] = 0;
              else if (m_rem[c] > 1) begin m_rem[c] = m_rem[c] - 1; m_ph[c] = 0; end
              else begin m_rem[c] = 0; m_ph[c] = 2; end
            end else m_cnt[c] = m_cnt[c] + 1;
          end
        end
        m_out[c] = m_nmask[c] && (m_ph[c] == 0);
      end
      for (int c = 0; c < 2; c++) begin
        if (wr_en && !m_mask[c]) begin
          if (wr_code == 8'(16 + 2*c)) m_hi[c] = wr_data;
          if (wr_code == 8'(17 + 2*c)) m_lo[c] = wr_data;
          if (wr_code == 8'(20 + c))   m_bc[c] = wr_data;
        end
      end
      m_mask = m_nmask;
    end
  end

  // per-cycle comparison against the model (R4, R6, R7, R8, R9)
  always @(negedge clk) begin
    if (started && !rst) begin
      for (int c = 0; c < 2; c++) begin
        checks++;
        if (pwm_out[c] !== m_out[c]) begin
          errors++;
          $display("FAIL R4/R9 ch%0d cycle %0d: actual %b expected %b",
                   c, cycles, pwm_out[c], m_out[c]);
        end
        if (pwm_out[c] && !prev_out[c]) rise[c]++;
      end
      prev_out = pwm_out;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles >= 20000 && !done) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    forever begin
      repeat (4) @(negedge clk);
      tick = tick_run;
      @(negedge clk);
      tick = 1'b0;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] code, input logic [15:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_code = code; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input string req, input logic [7:0] code, input int exp);
    @(negedge clk);
    rd_code = code;
    @(negedge clk);
    chk(req, rd_data, exp);
  endtask

  initial begin
    int r0, r1;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    started = 1'b1;
    // R1 reset state
    chk("R1 pwm", pwm_out, 0);
    chk("R1 rd", rd_data, 0);
    rd("R1 hi0", 8'h10, 0);
    rd("R1 mask", 8'h1F, 0);

    // R2 configuration and readback
    wr(8'h10, 16'd3); wr(8'h11, 16'd2); wr(8'h14, 16'd2);
    wr(8'h12, 16'd0); wr(8'h13, 16'd0); wr(8'h15, 16'd0);
    wr(8'h13, 16'hABCD); wr(8'h13, 16'd0);
    rd("R2 hi0", 8'h10, 3);
    rd("R2 lo0", 8'h11, 2);
    rd("R2 cnt0", 8'h14, 2);
    rd("R2 lo1", 8'h13, 0);
    rd("R2 unmapped", 8'h07, 0);

    tick_run = 1'b1;
    r0 = rise[0]; r1 = rise[1];
    @(negedge clk);
    wr_en = 1'b1; wr_code = 8'h1F; wr_data = 16'h0003;
    @(negedge clk);
    wr_en = 1'b0;
    chk("R4 enable high", pwm_out, 3);
    rd("R2 mask", 8'h1F, 3);
    repeat (150) @(negedge clk);
    chk("R6 burst of two", rise[0] - r0, 2);
    chk("R6 held low", pwm_out[0], 0);
    chk("R7 R8 continuous", (rise[1] - r1 >= 10) ? 1 : 0, 1);

    // R3 write ignored while enabled
    wr(8'h10, 16'd9);
    rd("R3 hi0 frozen", 8'h10, 3);
    wr(8'h15, 16'd4);
    rd("R3 cnt1 frozen", 8'h15, 0);

    // R5 disable forces low
    repeat (3) @(negedge clk);
    wr_en = 1'b1; wr_code = 8'h1F; wr_data = 16'h0001;
    @(negedge clk);
    wr_en = 1'b0;
    chk("R5 ch1 low", pwm_out[1], 0);

    // R5 R6 re-arm channel 0 for a single pulse
    wr(8'h1F, 16'h0000);
    chk("R5 all low", pwm_out, 0);
    wr(8'h14, 16'd1); wr(8'h10, 16'd1); wr(8'h11, 16'd4);
    r0 = rise[0];
    @(negedge clk);
    wr_en = 1'b1; wr_code = 8'h1F; wr_data = 16'h0001;
    @(negedge clk);
    wr_en = 1'b0;
    chk("R5 restart high", pwm_out[0], 1);
    repeat (100) @(negedge clk);
    chk("R6 single pulse", rise[0] - r0, 1);
    chk("R6 final low", pwm_out[0], 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule